// File: doc/BRIEF.md
# Self-Repairing Segmented Adder with Shared Spare

This block is a combinational adder, clocked only for its repair state. The operand width is cut into equal ripple segments. A sparse parallel-prefix tree works on per-segment generate and propagate terms and supplies the carry into each segment. Each segment then forms its own sum bits with a short ripple chain. One extra ripple segment, the spare, shares the same carry tree. A stuck-at fault can be forced onto any sum bit, or onto the carry-out, of any active segment through the fault injection inputs.

While no fault is known, the spare checks the adder online. A rotating pointer picks one active segment per clock cycle. The spare recomputes that segment from the same operand slice and the same carry-in, and a comparator flags any difference. On the first difference the pointer value is latched into a sticky register and the fault flag rises. From then on, output multiplexers take that segment's sum bits (and, for the top segment, the carry-out) from the spare. Checking stops, because no spare is left. The adder keeps producing correct sums, but a second fault is no longer detected.

Top module: `gda_adder`

## Requirements
- R1: With fault injection disabled, `{cout_o, sum_o}` equals `a_i + b_i + cin_i` for every operand pattern, including carries that run through all segments.
- R2: After reset, `fault_det_o` is 0 and `fault_seg_o` is 0.
- R3: While `fault_det_o` is 0, the checked segment index advances by one every clock cycle and wraps from NUM_SEG-1 to 0. A fault that produces a steady mismatch is therefore flagged within NUM_SEG+1 cycles of reset release.
- R4: When the spare and the checked segment differ at a clock edge, `fault_det_o` is 1 after that edge and `fault_seg_o` gives the index of the checked segment.
- R5: `fault_det_o` and `fault_seg_o` are sticky. They hold until reset, even if injection is removed or a fault is injected into another segment.
- R6: Once `fault_det_o` is 1, the sum and carry-out are correct for all operands while the fault stays in the replaced segment.
- R7: Before detection, an injected fault corrupts only the bits of its own segment. These are sum bits `[s*SEG_W +: SEG_W]`, plus `cout_o` when s is the top segment.
- R8: `fault_seg_o` reads 0 whenever `fault_det_o` is 0.
- R9: A stuck value that equals the correct bit value causes no mismatch, so the flag stays 0.
- R10: `flt_bit_i` values 0..SEG_W-1 force a sum bit of segment `flt_seg_i`, and the value SEG_W forces that segment's carry-out. A carry-out fault on the top segment is detected, and `cout_o` is then taken from the spare.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for pointer and repair state |
| rst_ni | input | 1 | Active-low asynchronous reset |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| cin_i | input | 1 | Carry-in |
| flt_en_i | input | 1 | Enables fault injection |
| flt_seg_i | input | SEG_IDX_W | Segment that receives the fault |
| flt_bit_i | input | FB_W | Bit forced: 0..SEG_W-1 sum bit, SEG_W carry-out |
| flt_val_i | input | 1 | Stuck-at value |
| sum_o | output | WIDTH | Sum |
| cout_o | output | 1 | Carry-out |
| fault_det_o | output | 1 | Sticky fault-detected flag |
| fault_seg_o | output | SEG_IDX_W | Replaced segment index, 0 when flag is low |

## Verification
The bench injects faults on a middle segment and on the top segment's carry-out, and also injects random faults. Before detection, corruption must stay inside the faulty segment. If the spare were wired to the wrong carry-in, errors would appear in other segments, or the flag would rise with no fault present. After detection the bench keeps the fault active and checks random sums. A multiplexer that picks the wrong segment, or a comparator that keeps running after the repair, would give wrong sums or move the latched index. A fault injected into a second segment, and a stuck value that matches the true bit, both test stickiness and mismatch-only detection.

// File: rtl/gda_pkg.sv
package gda_pkg;
  typedef struct packed {
    logic g;
    logic p;
  } gp_t;

  function automatic gp_t gp_merge(gp_t hi, gp_t lo);
    gp_t r;
    r.g = hi.g | (hi.p & lo.g);
    r.p = hi.p & lo.p;
    return r;
  endfunction
endpackage

// File: rtl/gda_ripple_seg.sv
module gda_ripple_seg #(
  parameter int SEG_W = 4
) (
  input  logic [SEG_W-1:0] a_i,
  input  logic [SEG_W-1:0] b_i,
  input  logic             cin_i,
  output logic [SEG_W-1:0] sum_o,
  output logic             cout_o
);
  always_comb begin
    logic c;
    c = cin_i;
    for (int i = 0; i < SEG_W; i++) begin
      sum_o[i] = a_i[i] ^ b_i[i] ^ c;
      c        = (a_i[i] & b_i[i]) | ((a_i[i] ^ b_i[i]) & c);
    end
    cout_o = c;
  end
endmodule

// File: rtl/gda_prefix_tree.sv
module gda_prefix_tree
  import gda_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SEG_W = 4
) (
  input  logic [WIDTH-1:0]           a_i,
  input  logic [WIDTH-1:0]           b_i,
  input  logic                       cin_i,
  output logic [WIDTH/SEG_W:0]       c_o
);
  localparam int NUM_SEG = WIDTH / SEG_W;
  localparam int LVL     = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1;

  gp_t seg_gp [NUM_SEG];
  gp_t lvl_gp [LVL+1][NUM_SEG];

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_grp
    always_comb begin
      logic g, p, ai, bi;
      g = 1'b0;
      p = 1'b1;
      for (int i = 0; i < SEG_W; i++) begin
        ai = a_i[s*SEG_W+i];
        bi = b_i[s*SEG_W+i];
        g  = (ai & bi) | ((ai ^ bi) & g);
        p  = p & (ai ^ bi);
      end
      seg_gp[s] = '{g: g, p: p};
    end
  end

  // fold carry-in into segment 0 so the tree output is the carry directly
  assign lvl_gp[0][0] = '{g: seg_gp[0].g | (seg_gp[0].p & cin_i), p: 1'b0};
  for (genvar s = 1; s < NUM_SEG; s++) begin : g_l0
    assign lvl_gp[0][s] = seg_gp[s];
  end

  for (genvar l = 0; l < LVL; l++) begin : g_lvl
    for (genvar s = 0; s < NUM_SEG; s++) begin : g_node
      if (s >= (1 << l)) begin : g_mrg
        assign lvl_gp[l+1][s] = gp_merge(lvl_gp[l][s], lvl_gp[l][s-(1<<l)]);
      end else begin : g_pass
        assign lvl_gp[l+1][s] = lvl_gp[l][s];
      end
    end
  end

  assign c_o[0] = cin_i;
  for (genvar s = 0; s < NUM_SEG; s++) begin : g_c
    assign c_o[s+1] = lvl_gp[LVL][s].g;
  end
endmodule

// File: rtl/gda_check_ctl.sv
module gda_check_ctl #(
  parameter int NUM_SEG = 8,
  localparam int IDX_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mismatch_i,
  output logic [IDX_W-1:0] sel_o,
  output logic             det_o,
  output logic [IDX_W-1:0] idx_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_SEG - 1);

  logic [IDX_W-1:0] ptr_q;
  logic             det_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      det_q <= 1'b0;
      idx_q <= '0;
    end else if (!det_q) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
      if (mismatch_i) begin
        det_q <= 1'b1;
        idx_q <= ptr_q;
      end
    end
  end

  assign sel_o = det_q ? idx_q : ptr_q;
  assign det_o = det_q;
  assign idx_o = det_q ? idx_q : '0;

  // R3
  ptr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !det_q |=> (ptr_q == (($past(ptr_q) == LAST) ? '0 : $past(ptr_q) + 1'b1)));
  // R4
  latch_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!det_q && mismatch_i) |=> (det_q && idx_q == $past(ptr_q)));
  // R5
  det_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_q |=> det_q);
  // R5
  idx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    det_q |=> $stable(idx_q));
endmodule

// File: rtl/gda_adder.sv
module gda_adder #(
  parameter int WIDTH    = 32,
  parameter int SEG_W    = 4,
  localparam int NUM_SEG   = WIDTH / SEG_W,
  localparam int SEG_IDX_W = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
  localparam int FB_W      = $clog2(SEG_W + 1)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [WIDTH-1:0]     a_i,
  input  logic [WIDTH-1:0]     b_i,
  input  logic                 cin_i,
  input  logic                 flt_en_i,
  input  logic [SEG_IDX_W-1:0] flt_seg_i,
  input  logic [FB_W-1:0]      flt_bit_i,
  input  logic                 flt_val_i,
  output logic [WIDTH-1:0]     sum_o,
  output logic                 cout_o,
  output logic                 fault_det_o,
  output logic [SEG_IDX_W-1:0] fault_seg_o
);
  localparam logic [SEG_IDX_W-1:0] LAST = SEG_IDX_W'(NUM_SEG - 1);

  logic [NUM_SEG:0]       seg_c;
  logic [SEG_W-1:0]       raw_sum  [NUM_SEG];
  logic                   raw_cout [NUM_SEG];
  logic [SEG_W-1:0]       act_sum  [NUM_SEG];
  logic                   act_cout [NUM_SEG];
  logic [SEG_W-1:0]       spr_sum;
  logic                   spr_cout;
  logic [SEG_IDX_W-1:0]   sel;
  logic                   det;
  logic [SEG_IDX_W-1:0]   det_idx;
  logic                   mismatch;

  gda_prefix_tree #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_tree (
    .a_i(a_i), .b_i(b_i), .cin_i(cin_i), .c_o(seg_c)
  );

  for (genvar s = 0; s < NUM_SEG; s++) begin : g_seg
    gda_ripple_seg #(.SEG_W(SEG_W)) u_seg (
      .a_i(a_i[s*SEG_W +: SEG_W]), .b_i(b_i[s*SEG_W +: SEG_W]),
      .cin_i(seg_c[s]), .sum_o(raw_sum[s]), .cout_o(raw_cout[s])
    );

    always_comb begin
      act_sum[s]  = raw_sum[s];
      act_cout[s] = raw_cout[s];
      if (flt_en_i && flt_seg_i == SEG_IDX_W'(s)) begin
        if (flt_bit_i == FB_W'(SEG_W)) act_cout[s] = flt_val_i;
        else if (flt_bit_i < FB_W'(SEG_W)) act_sum[s][flt_bit_i] = flt_val_i;
      end
    end

    assign sum_o[s*SEG_W +: SEG_W] = (det && det_idx == SEG_IDX_W'(s)) ? spr_sum : act_sum[s];
  end

  gda_ripple_seg #(.SEG_W(SEG_W)) u_spare (
    .a_i(a_i[sel*SEG_W +: SEG_W]), .b_i(b_i[sel*SEG_W +: SEG_W]),
    .cin_i(seg_c[sel]), .sum_o(spr_sum), .cout_o(spr_cout)
  );

  assign mismatch = !det && ({spr_cout, spr_sum} != {act_cout[sel], act_sum[sel]});
  assign cout_o   = (det && det_idx == LAST) ? spr_cout : act_cout[NUM_SEG-1];

  gda_check_ctl #(.NUM_SEG(NUM_SEG)) u_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .mismatch_i(mismatch),
    .sel_o(sel), .det_o(det), .idx_o(det_idx)
  );

  assign fault_det_o = det;
  assign fault_seg_o = det_idx;

  // R1
  clean_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flt_en_i |-> ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i))));
  // R6
  repaired_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_det_o && (!flt_en_i || flt_seg_i == fault_seg_o)) |->
      ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + (WIDTH+1)'(cin_i))));
  // R8
  idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_det_o |-> (fault_seg_o == '0));
endmodule

// File: tb/gda_adder_tb.sv
module gda_adder_tb;
  localparam int WIDTH   = 32;
  localparam int SEG_W   = 4;
  localparam int NUM_SEG = WIDTH / SEG_W;
  localparam int IW      = $clog2(NUM_SEG);
  localparam int FBW     = $clog2(SEG_W + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [WIDTH-1:0] a = '0, b = '0;
  logic             cin = 1'b0;
  logic             flt_en = 1'b0;
  logic [IW-1:0]    flt_seg = '0;
  logic [FBW-1:0]   flt_bit = '0;
  logic             flt_val = 1'b0;
  logic [WIDTH-1:0] sum;
  logic             cout;
  logic             det;
  logic [IW-1:0]    det_seg;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  gda_adder #(.WIDTH(WIDTH), .SEG_W(SEG_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a), .b_i(b), .cin_i(cin),
    .flt_en_i(flt_en), .flt_seg_i(flt_seg), .flt_bit_i(flt_bit), .flt_val_i(flt_val),
    .sum_o(sum), .cout_o(cout), .fault_det_o(det), .fault_seg_o(det_seg)
  );

  always #10 clk = ~clk;

  function automatic logic [WIDTH:0] ref_add(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + (WIDTH+1)'(c);
  endfunction

  function automatic logic [WIDTH:0] seg_mask(int s);
    logic [WIDTH:0] m;
    m = '0;
    for (int i = 0; i < SEG_W; i++) m[s*SEG_W+i] = 1'b1;
    if (s == NUM_SEG-1) m[WIDTH] = 1'b1;
    return m;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic do_reset();
    flt_en = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic drive(logic [WIDTH-1:0] x, logic [WIDTH-1:0] y, logic c);
    @(negedge clk);
    a = x; b = y; cin = c;
    #2;
  endtask

  task automatic inject(int s, int bt, logic v);
    flt_seg = IW'(s); flt_bit = FBW'(bt); flt_val = v; flt_en = 1'b1;
  endtask

  // runs until detection; checks confinement before it; returns cycles used
  task automatic run_to_detect(int s, bit rnd, int cap, output int cycles);
    logic [WIDTH:0] e;
    cycles = cap;
    for (int k = 1; k <= cap; k++) begin
      if (rnd) drive({$urandom}, {$urandom}, 1'($urandom));
      else drive('0, '0, 1'b0);
      e = ref_add(a, b, cin);
      if (det) begin cycles = k; break; end
      check((({cout, sum} ^ e) & ~seg_mask(s)) == '0, "R7 confinement",
            64'({cout, sum}), 64'(e));
      check(det_seg == '0, "R8 idx zero while clear", 64'(det_seg), 0);
    end
  endtask

  task automatic random_sums(int n, string req);
    logic [WIDTH:0] e;
    for (int k = 0; k < n; k++) begin
      drive({$urandom}, {$urandom}, 1'($urandom));
      e = ref_add(a, b, cin);
      check({cout, sum} == e, req, 64'({cout, sum}), 64'(e));
    end
  endtask

  initial begin
    int cyc;
    logic [WIDTH:0] e;
    void'($urandom(32'd20240611));
    do_reset();
    #2;
    check(det == 1'b0, "R2 flag after reset", 64'(det), 0);
    check(det_seg == '0, "R2 index after reset", 64'(det_seg), 0);

    // R1 directed corners
    drive('1, '0, 1'b1);  e = ref_add(a, b, cin);
    check({cout, sum} == e, "R1 full carry ripple", 64'({cout, sum}), 64'(e));
    drive('1, '1, 1'b1);  e = ref_add(a, b, cin);
    check({cout, sum} == e, "R1 all ones", 64'({cout, sum}), 64'(e));
    drive({(WIDTH/2){2'b10}}, {(WIDTH/2){2'b01}}, 1'b1); e = ref_add(a, b, cin);
    check({cout, sum} == e, "R1 alternating", 64'({cout, sum}), 64'(e));
    drive('0, '0, 1'b0);  e = ref_add(a, b, cin);
    check({cout, sum} == e, "R1 zero", 64'({cout, sum}), 64'(e));
    random_sums(300, "R1 random no fault");
    check(det == 1'b0, "R1 no false detection", 64'(det), 0);

    // R9: stuck value equals true bit
    inject(3, 1, 1'b0);
    for (int k = 0; k < 3*NUM_SEG; k++) drive('0, '0, 1'b0);
    check(det == 1'b0, "R9 matching stuck not flagged", 64'(det), 0);
    check({cout, sum} == '0, "R9 sum intact", 64'({cout, sum}), 0);

    // R3 R4 R7: steady mismatch in segment 5
    do_reset();
    inject(5, 2, 1'b1);
    run_to_detect(5, 1'b0, 4*NUM_SEG, cyc);
    check(det == 1'b1 && cyc <= NUM_SEG + 1, "R3 detect within one sweep", 64'(cyc), NUM_SEG+1);
    check(det_seg == IW'(5), "R4 latched index", 64'(det_seg), 5);

    // R6: fault still active, repaired output
    random_sums(200, "R6 repaired sums");
    drive('1, '0, 1'b1); e = ref_add(a, b, cin);
    check({cout, sum} == e, "R6 repaired carry chain", 64'({cout, sum}), 64'(e));

    // R5: second fault elsewhere and removal
    inject(2, 0, 1'b1);
    for (int k = 0; k < 2*NUM_SEG; k++) drive('0, '0, 1'b0);
    check(det == 1'b1, "R5 flag sticky", 64'(det), 1);
    check(det_seg == IW'(5), "R5 index kept on second fault", 64'(det_seg), 5);
    flt_en = 1'b0;
    for (int k = 0; k < 4; k++) drive('0, '0, 1'b0);
    check(det == 1'b1 && det_seg == IW'(5), "R5 kept after removal", 64'(det_seg), 5);
    do_reset(); #2;
    check(det == 1'b0 && det_seg == '0, "R2 reset clears", 64'(det), 0);

    // R10: carry-out fault on top segment
    inject(NUM_SEG-1, SEG_W, 1'b1);
    run_to_detect(NUM_SEG-1, 1'b0, 4*NUM_SEG, cyc);
    check(det == 1'b1, "R10 carry fault detected", 64'(det), 1);
    check(det_seg == IW'(NUM_SEG-1), "R10 top index", 64'(det_seg), NUM_SEG-1);
    drive('0, '0, 1'b0);
    check(cout == 1'b0, "R10 cout from spare", 64'(cout), 0);
    random_sums(100, "R10 repaired cout");

    // random faults with random operands
    for (int t = 0; t < 12; t++) begin
      int s, bt;
      s  = int'($urandom_range(NUM_SEG-1));
      bt = int'($urandom_range(SEG_W));
      do_reset();
      inject(s, bt, 1'($urandom));
      run_to_detect(s, 1'b1, 600, cyc);
      check(det == 1'b1, "R4 random fault detected", 64'(det), 1);
      check(det_seg == IW'(s), "R4 random fault index", 64'(det_seg), 64'(s));
      random_sums(50, "R6 random repaired");
    end

    report();
  end

  initial begin
    for (int k = 0; k < 150000; k++) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end
endmodule